// File: doc/BRIEF.md
# Programmable PRBS Bit Error Tester

This block tests a serial link for bit errors. One configuration drives two halves. The transmit half runs a 32-bit shift register. It produces either a pseudo-random sequence or a repeating user word of programmable length, one bit per enabled cycle. The receive half loads 32 received bits into a second copy of that register and then lets it run freely. It compares each later received bit against the predicted bit, counts the mismatches and the checked bits, and reports whether it is locked.

The receive side is controlled by a state machine with three states. MON_LOAD fills the register from the line. MON_VERIFY requires a run of error-free bits. MON_SYNC is locked operation.
- MON_LOAD goes to MON_VERIFY once 32 bits are loaded.
- MON_VERIFY goes to MON_SYNC after 32 clean bits, or back to MON_LOAD on any mismatch.
- MON_SYNC goes to MON_LOAD when too many errors fall in one 64-bit block.
- A manual resync request forces MON_LOAD from any state.

A second machine runs the counter snapshot. It has two states, UPD_IDLE and UPD_BUSY. A rising request moves UPD_IDLE to UPD_BUSY, and UPD_BUSY always returns to UPD_IDLE on the next cycle. The transmit side can also invert one outgoing bit on request, and the receive side can invert incoming data before comparison.

Top module: `bert_core`

## Requirements
- R1: In pseudo-random mode (`cfg_rep`=0), the feedback is `s[cfg_len] ^ s[cfg_tap]` of the transmit register `s`. On each cycle with `tx_en`=1, `s` shifts toward the MSB and the feedback enters bit 0. `tx_bit` shows `s[cfg_len]`, and `s` holds when `tx_en`=0.
- R2: In repetitive mode (`cfg_rep`=1), the feedback is `s[cfg_len]`. After a load, the output repeats the low `cfg_len`+1 seed bits, most significant first, with period `cfg_len`+1.
- R3: `cfg_load`=1 copies `cfg_seed` into the transmit register. It takes priority over a shift in the same cycle.
- R4: A 0-to-1 change of `inj_req` while `cfg_inj_en`=1 inverts the next transmitted bit, and only that bit. With `cfg_inj_en`=0 the change has no effect.
- R5: After a resync, the monitor is in MON_SYNC (`mon_sync`=1) exactly after 64 received bits: 32 loaded plus 32 error-free. A mismatch during MON_VERIFY restarts the 32-bit load.
- R6: With `cfg_inv`=1, received data is inverted before use, so an inverted stream locks with no errors.
- R7: The live error and bit counters advance only for bits received in MON_SYNC. The error counter counts mismatches there, including the one that causes loss of sync.
- R8: In MON_SYNC, bits are grouped into blocks of 64 starting at sync entry. The sixth mismatch within one block returns the monitor to MON_LOAD, while five are tolerated.
- R9: A 0-to-1 change of `resync_req` puts the monitor in MON_LOAD on the next cycle, from any state.
- R10: A 0-to-1 change of `pm_req` copies the live counts to `hold_err` and `hold_bits`. It restarts each live counter at that cycle's own contribution (0 or 1), and `pm_ready` is 0 for the one following cycle.
- R11: Live counters saturate at all ones: error counter `ERR_W` bits (default 24), bit counter `BIT_W` bits (default 32).
- R12: After reset, `mon_sync`=0, `mon_oos`=1, `pm_ready`=1, both holding values are 0 and the transmit register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rep | input | 1 | 0 pseudo-random, 1 repetitive |
| cfg_len | input | 5 | Length field: pattern length minus one |
| cfg_tap | input | 5 | Second feedback tap index (pseudo-random mode) |
| cfg_seed | input | 32 | Seed or repeating word |
| cfg_load | input | 1 | Load seed into transmit register |
| cfg_inv | input | 1 | Invert received data |
| cfg_inj_en | input | 1 | Enable single-bit error insertion |
| inj_req | input | 1 | Error insertion request, rising edge |
| tx_en | input | 1 | Transmit clock enable |
| tx_bit | output | 1 | Transmit serial data |
| rx_en | input | 1 | Receive clock enable |
| rx_bit | input | 1 | Receive serial data |
| resync_req | input | 1 | Manual resync, rising edge |
| pm_req | input | 1 | Counter snapshot request, rising edge |
| pm_ready | output | 1 | 0 while a snapshot is in progress |
| mon_sync | output | 1 | Monitor locked |
| mon_oos | output | 1 | Monitor not locked |
| hold_err | output | ERR_W | Snapshot of bit error count |
| hold_bits | output | BIT_W | Snapshot of checked bit count |

## Verification
A snapshot request can land in the same cycle as a counted bit, including a mismatched one. The bench provokes this by raising `pm_req` on a cycle where an errored bit is also received in sync. It expects the first snapshot to hold the counts from before that cycle, and a second snapshot to show exactly one bit and one error. The sixth error of a block also coincides with the state change back to MON_LOAD. The bench checks that this error is still counted, and that five errors in a block do not break lock.

// File: rtl/bert_pkg.sv
package bert_pkg;
    localparam int PAT_W = 32;
    localparam int LEN_W = $clog2(PAT_W);

    typedef enum logic [1:0] {
        MON_LOAD   = 2'd0,
        MON_VERIFY = 2'd1,
        MON_SYNC   = 2'd2
    } mon_state_t;

    typedef enum logic {
        UPD_IDLE = 1'b0,
        UPD_BUSY = 1'b1
    } upd_state_t;
endpackage

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
#(
    parameter bit OUT_FEEDBACK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rep,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] tap,
    input  logic             load,
    input  logic [PAT_W-1:0] seed,
    input  logic             step,
    input  logic             use_din,
    input  logic             din,
    output logic             out_o
);
    logic [PAT_W-1:0] sr_q;
    logic             fb;

    always_comb begin
        fb = rep ? sr_q[len] : (sr_q[len] ^ sr_q[tap]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= seed;
        else if (step)
            sr_q <= {sr_q[PAT_W-2:0], (use_din ? din : fb)};
    end

    generate
        if (OUT_FEEDBACK) begin : g_predict
            assign out_o = fb;
        end else begin : g_head
            assign out_o = sr_q[len];
        end
    endgenerate
endmodule

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
    import bert_pkg::*;
#(
    parameter int GOOD_BITS = 32,
    parameter int LOS_ERRS  = 6,
    parameter int LOS_WIN   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic bit_err,
    input  logic resync_req,
    output logic use_din,
    output logic mon_sync
);
    localparam int RUN_MAX = (PAT_W > GOOD_BITS) ? PAT_W : GOOD_BITS;
    localparam int CNT_W   = $clog2(RUN_MAX);
    localparam int WIN_W   = $clog2(LOS_WIN);
    localparam int ERR_CW  = $clog2(LOS_ERRS + 1);

    mon_state_t       st_q, st_d;
    logic [CNT_W-1:0]  run_q;
    logic [WIN_W-1:0]  win_q;
    logic [ERR_CW-1:0] werr_q;
    logic              resync_q;
    logic              resync_edge;

    assign resync_edge = resync_req & ~resync_q;

    always_comb begin
        st_d = st_q;
        if (resync_edge) begin
            st_d = MON_LOAD;
        end else if (rx_en) begin
            unique case (st_q)
                MON_LOAD:   if (run_q == CNT_W'(PAT_W - 1)) st_d = MON_VERIFY;
                MON_VERIFY: if (bit_err) st_d = MON_LOAD;
                            else if (run_q == CNT_W'(GOOD_BITS - 1)) st_d = MON_SYNC;
                MON_SYNC:   if (bit_err && werr_q == ERR_CW'(LOS_ERRS - 1)) st_d = MON_LOAD;
                default:    st_d = MON_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MON_LOAD;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resync_q <= 1'b0;
            run_q    <= '0;
            win_q    <= '0;
            werr_q   <= '0;
        end else begin
            resync_q <= resync_req;
            if (st_d != st_q || resync_edge)
                run_q <= '0;
            else if (rx_en && st_q != MON_SYNC)
                run_q <= run_q + 1'b1;
            if (st_q != MON_SYNC || st_d != MON_SYNC) begin
                win_q  <= '0;
                werr_q <= '0;
            end else if (rx_en) begin
                if (win_q == WIN_W'(LOS_WIN - 1)) begin
                    win_q  <= '0;
                    werr_q <= '0;
                end else begin
                    win_q  <= win_q + 1'b1;
                    werr_q <= werr_q + ERR_CW'(bit_err);
                end
            end
        end
    end

    always_comb begin
        use_din  = (st_q == MON_LOAD);
        mon_sync = (st_q == MON_SYNC);
    end

    assert_sync_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_sync) |-> $past(st_q) == MON_VERIFY);
    assert_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resync_edge |=> st_q == MON_LOAD);
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        werr_q < ERR_CW'(LOS_ERRS));
endmodule

// File: rtl/bert_counters.sv
module bert_counters
    import bert_pkg::*;
#(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_inc,
    input  logic             err_inc,
    input  logic             pm_req,
    output logic             pm_ready,
    output logic [ERR_W-1:0] hold_err,
    output logic [BIT_W-1:0] hold_bits
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;
    localparam logic [BIT_W-1:0] BIT_MAX = '1;

    upd_state_t       st_q, st_d;
    logic             pm_q;
    logic             cap;
    logic [ERR_W-1:0] err_q;
    logic [BIT_W-1:0] bits_q;

    assign cap = pm_req & ~pm_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UPD_IDLE: if (cap) st_d = UPD_BUSY;
            UPD_BUSY: st_d = UPD_IDLE;
            default:  st_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UPD_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q      <= 1'b0;
            err_q     <= '0;
            bits_q    <= '0;
            hold_err  <= '0;
            hold_bits <= '0;
        end else begin
            pm_q <= pm_req;
            if (cap) begin
                hold_err  <= err_q;
                hold_bits <= bits_q;
                err_q     <= ERR_W'(err_inc);
                bits_q    <= BIT_W'(bit_inc);
            end else begin
                if (err_inc && err_q != ERR_MAX) err_q  <= err_q + 1'b1;
                if (bit_inc && bits_q != BIT_MAX) bits_q <= bits_q + 1'b1;
            end
        end
    end

    always_comb pm_ready = (st_q == UPD_IDLE);

    assert_hold_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (hold_err == $past(err_q) && hold_bits == $past(bits_q)));
    assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !pm_ready);
    assert_err_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == ERR_MAX && !cap) |=> err_q == ERR_MAX);
    assert_bits_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_q == BIT_MAX && !cap) |=> bits_q == BIT_MAX);
endmodule

// File: rtl/bert_core.sv
module bert_core
    import bert_pkg::*;
#(
    parameter int ERR_W     = 24,
    parameter int BIT_W     = 32,
    parameter int GOOD_BITS = 32,
    parameter int LOS_ERRS  = 6,
    parameter int LOS_WIN   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rep,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [LEN_W-1:0] cfg_tap,
    input  logic [PAT_W-1:0] cfg_seed,
    input  logic             cfg_load,
    input  logic             cfg_inv,
    input  logic             cfg_inj_en,
    input  logic             inj_req,
    input  logic             tx_en,
    output logic             tx_bit,
    input  logic             rx_en,
    input  logic             rx_bit,
    input  logic             resync_req,
    input  logic             pm_req,
    output logic             pm_ready,
    output logic             mon_sync,
    output logic             mon_oos,
    output logic [ERR_W-1:0] hold_err,
    output logic [BIT_W-1:0] hold_bits
);
    logic tx_head, rx_pred, rx_d, bit_err, use_din;
    logic inj_q, inj_pend_q, inj_edge;

    assign rx_d     = rx_bit ^ cfg_inv;
    assign bit_err  = rx_d ^ rx_pred;
    assign inj_edge = inj_req & ~inj_q & cfg_inj_en;
    assign tx_bit   = tx_head ^ inj_pend_q;
    assign mon_oos  = ~mon_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inj_q      <= 1'b0;
            inj_pend_q <= 1'b0;
        end else begin
            inj_q      <= inj_req;
            inj_pend_q <= (inj_pend_q & ~tx_en) | inj_edge;
        end
    end

    bert_patgen #(.OUT_FEEDBACK(1'b0)) u_txgen (
        .clk(clk), .rst_n(rst_n), .rep(cfg_rep), .len(cfg_len), .tap(cfg_tap),
        .load(cfg_load), .seed(cfg_seed), .step(tx_en), .use_din(1'b0),
        .din(1'b0), .out_o(tx_head)
    );

    bert_patgen #(.OUT_FEEDBACK(1'b1)) u_rxgen (
        .clk(clk), .rst_n(rst_n), .rep(cfg_rep), .len(cfg_len), .tap(cfg_tap),
        .load(1'b0), .seed('0), .step(rx_en), .use_din(use_din),
        .din(rx_d), .out_o(rx_pred)
    );

    bert_sync_fsm #(.GOOD_BITS(GOOD_BITS), .LOS_ERRS(LOS_ERRS), .LOS_WIN(LOS_WIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_err(bit_err),
        .resync_req(resync_req), .use_din(use_din), .mon_sync(mon_sync)
    );

    bert_counters #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bit_inc(rx_en & mon_sync),
        .err_inc(rx_en & mon_sync & bit_err), .pm_req(pm_req),
        .pm_ready(pm_ready), .hold_err(hold_err), .hold_bits(hold_bits)
    );

    assert_inj_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !inj_edge) |=> !inj_pend_q);
    assert_inj_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_inj_en && !inj_pend_q) |=> !inj_pend_q);
endmodule

// File: tb/tb_bert_core.sv
module tb_bert_core;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rep = 1'b0;
    logic [4:0]  cfg_len = 5'd14;
    logic [4:0]  cfg_tap = 5'd13;
    logic [31:0] cfg_seed = 32'h0000_3ACE;
    logic        cfg_load = 1'b0, cfg_inv = 1'b0, cfg_inj_en = 1'b0, inj_req = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, rx_bit = 1'b0, rx_bit_s = 1'b0;
    logic        resync_req = 1'b0, pm_req = 1'b0;
    logic        tx_bit, pm_ready, mon_sync, mon_oos;
    logic        tx_bit_s, pm_ready_s, mon_sync_s, mon_oos_s;
    logic [23:0] hold_err;
    logic [31:0] hold_bits;
    logic [2:0]  hold_err_s;
    logic [7:0]  hold_bits_s;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    bert_core dut (
        .clk(clk), .rst_n(rst_n), .cfg_rep(cfg_rep), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_seed(cfg_seed), .cfg_load(cfg_load), .cfg_inv(cfg_inv), .cfg_inj_en(cfg_inj_en),
        .inj_req(inj_req), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en), .rx_bit(rx_bit),
        .resync_req(resync_req), .pm_req(pm_req), .pm_ready(pm_ready), .mon_sync(mon_sync),
        .mon_oos(mon_oos), .hold_err(hold_err), .hold_bits(hold_bits)
    );

    bert_core #(.ERR_W(3), .BIT_W(8)) dut_sat (
        .clk(clk), .rst_n(rst_n), .cfg_rep(cfg_rep), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_seed(cfg_seed), .cfg_load(cfg_load), .cfg_inv(cfg_inv), .cfg_inj_en(cfg_inj_en),
        .inj_req(inj_req), .tx_en(tx_en), .tx_bit(tx_bit_s), .rx_en(rx_en), .rx_bit(rx_bit_s),
        .resync_req(resync_req), .pm_req(pm_req), .pm_ready(pm_ready_s), .mon_sync(mon_sync_s),
        .mon_oos(mon_oos_s), .hold_err(hold_err_s), .hold_bits(hold_bits_s)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic loop_bits(input int n, input int f_lo, input int f_hi, input logic inv);
        for (int i = 0; i < n; i++) begin
            tx_en    = 1'b1;
            rx_en    = 1'b1;
            rx_bit   = tx_bit   ^ inv ^ (i >= f_lo && i < f_hi);
            rx_bit_s = tx_bit_s ^ inv ^ (i >= f_lo && i < f_hi);
            tick();
        end
        tx_en = 1'b0;
        rx_en = 1'b0;
    endtask

    task automatic resync_pulse();
        resync_req = 1'b1;
        tick();
        resync_req = 1'b0;
        tick();
    endtask

    task automatic pm_pulse(input string req);
        pm_req = 1'b1;
        tick();
        chk({req, " pm_ready low"}, pm_ready, 0);
        pm_req = 1'b0;
        tick();
        chk({req, " pm_ready back"}, pm_ready, 1);
    endtask

    task automatic load_seed();
        cfg_load = 1'b1;
        tx_en    = 1'b1;
        tick();
        cfg_load = 1'b0;
        tx_en    = 1'b0;
    endtask

    task automatic acquire(input logic inv);
        resync_pulse();
        loop_bits(64, -1, -1, inv);
        chk("R5 acquire", mon_sync, 1);
    endtask

    task automatic t_reset();
        chk("R12 mon_sync", mon_sync, 0);
        chk("R12 mon_oos", mon_oos, 1);
        chk("R12 pm_ready", pm_ready, 1);
        chk("R12 hold_err", hold_err, 0);
        chk("R12 hold_bits", hold_bits, 0);
        chk("R12 tx_bit", tx_bit, 0);
    endtask

    task automatic t_prbs();
        logic [31:0] m;
        int mism = 0;
        load_seed();
        m = cfg_seed;
        chk("R3 load over shift", tx_bit, m[cfg_len]);
        for (int k = 0; k < 100; k++) begin
            if (tx_bit !== m[cfg_len]) mism++;
            tx_en = 1'b1;
            tick();
            m = {m[30:0], m[cfg_len] ^ m[cfg_tap]};
        end
        tx_en = 1'b0;
        chk("R1 prbs sequence mismatches", mism, 0);
        tick();
        tick();
        chk("R1 hold without tx_en", tx_bit, m[cfg_len]);
    endtask

    task automatic t_rep();
        int mism = 0;
        cfg_rep  = 1'b1;
        cfg_len  = 5'd7;
        cfg_seed = 32'h0000_00A5;
        load_seed();
        for (int k = 0; k < 24; k++) begin
            if (tx_bit !== cfg_seed[7 - (k % 8)]) mism++;
            tx_en = 1'b1;
            tick();
        end
        tx_en = 1'b0;
        chk("R2 repetitive mismatches", mism, 0);
        acquire(1'b0);
        pm_pulse("R2");
        loop_bits(40, -1, -1, 1'b0);
        pm_pulse("R2");
        chk("R2 repetitive lock errors", hold_err, 0);
        cfg_rep  = 1'b0;
        cfg_len  = 5'd14;
        cfg_seed = 32'h0000_3ACE;
        load_seed();
    endtask

    task automatic t_acquire();
        resync_pulse();
        loop_bits(63, -1, -1, 1'b0);
        chk("R5 not yet in sync at 63", mon_sync, 0);
        loop_bits(1, -1, -1, 1'b0);
        chk("R5 in sync at 64", mon_sync, 1);
        resync_pulse();
        loop_bits(101, 37, 38, 1'b0);
        chk("R5 verify error reloads", mon_sync, 0);
        loop_bits(1, -1, -1, 1'b0);
        chk("R5 sync after reload", mon_sync, 1);
    endtask

    task automatic t_count();
        pm_pulse("R7");
        loop_bits(40, 10, 11, 1'b0);
        loop_bits(1, 0, 1, 1'b0);
        pm_pulse("R7");
        chk("R7 errors in sync", hold_err, 2);
        chk("R7 bits in sync", hold_bits, 41);
        resync_pulse();
        pm_pulse("R7");
        loop_bits(40, 35, 36, 1'b0);
        pm_pulse("R7");
        chk("R7 no error count out of sync", hold_err, 0);
        chk("R7 no bit count out of sync", hold_bits, 0);
    endtask

    task automatic t_inject();
        acquire(1'b0);
        pm_pulse("R4");
        cfg_inj_en = 1'b0;
        inj_req = 1'b1;
        tick();
        inj_req = 1'b0;
        loop_bits(30, -1, -1, 1'b0);
        pm_pulse("R4");
        chk("R4 disabled insertion ignored", hold_err, 0);
        cfg_inj_en = 1'b1;
        inj_req = 1'b1;
        tick();
        inj_req = 1'b0;
        loop_bits(30, -1, -1, 1'b0);
        pm_pulse("R4");
        chk("R4 single inserted error", hold_err, 1);
        chk("R4 still in sync", mon_sync, 1);
        cfg_inj_en = 1'b0;
    endtask

    task automatic t_invert();
        cfg_inv = 1'b1;
        acquire(1'b1);
        pm_pulse("R6");
        loop_bits(50, -1, -1, 1'b1);
        pm_pulse("R6");
        chk("R6 inverted errors", hold_err, 0);
        chk("R6 inverted bits", hold_bits, 50);
        cfg_inv = 1'b0;
    endtask

    task automatic t_los();
        acquire(1'b0);
        pm_pulse("R8");
        loop_bits(5, 0, 5, 1'b0);
        chk("R8 five errors keep sync", mon_sync, 1);
        loop_bits(59, -1, -1, 1'b0);
        loop_bits(5, 0, 5, 1'b0);
        chk("R8 five in new block keep sync", mon_sync, 1);
        loop_bits(1, 0, 1, 1'b0);
        chk("R8 sixth error drops sync", mon_sync, 0);
        chk("R8 oos flag", mon_oos, 1);
        pm_pulse("R8");
        chk("R7 sixth error counted", hold_err, 11);
    endtask

    task automatic t_resync();
        acquire(1'b0);
        resync_req = 1'b1;
        tick();
        chk("R9 resync drops sync", mon_sync, 0);
        resync_req = 1'b0;
        tick();
    endtask

    task automatic t_collide();
        acquire(1'b0);
        pm_pulse("R10");
        loop_bits(10, 3, 4, 1'b0);
        pm_req = 1'b1;
        tx_en  = 1'b1;
        rx_en  = 1'b1;
        rx_bit   = ~tx_bit;
        rx_bit_s = ~tx_bit_s;
        tick();
        tx_en  = 1'b0;
        rx_en  = 1'b0;
        pm_req = 1'b0;
        chk("R10 collide hold_err", hold_err, 1);
        chk("R10 collide hold_bits", hold_bits, 10);
        tick();
        pm_pulse("R10");
        chk("R10 carried error", hold_err, 1);
        chk("R10 carried bit", hold_bits, 1);
    endtask

    task automatic t_sat();
        acquire(1'b0);
        pm_pulse("R11");
        loop_bits(64, 0, 5, 1'b0);
        loop_bits(236, 0, 5, 1'b0);
        pm_pulse("R11");
        chk("R11 wide errors", hold_err, 10);
        chk("R11 wide bits", hold_bits, 300);
        chk("R11 narrow errors saturate", hold_err_s, 7);
        chk("R11 narrow bits saturate", hold_bits_s, 255);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_prbs();
        t_rep();
        t_acquire();
        t_count();
        t_inject();
        t_invert();
        t_los();
        t_resync();
        t_collide();
        t_sat();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule